// File: doc/BRIEF.md
# Dual-Plane Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh. It has five ports: a local port toward the node's own endpoint, and one port toward each of the four mesh neighbours. Packets cross it as a stream of flits. The first flit of a packet carries the destination coordinates and claims an output. The flits behind it follow over that same output. The last flit gives the output up again.

Two complete router planes sit side by side, one for request traffic and one for reply traffic. They share no buffer, no arbiter and no credit. A full request network therefore can never hold back a reply.

Every plane input has a flit FIFO whose depth is a parameter. Flow control is credit based in both directions: the node forwards a flit only while it holds a credit for the neighbour's buffer, and it returns one credit upstream for each flit that leaves one of its own FIFOs. Routing is dimension-ordered, X before Y. Each output is followed by a register chain of configurable length, which models the per-hop flit delay.

Top module: `mesh_router_dual`

## Requirements
- R1: After reset, no output is valid and no credit pulse is returned until a flit has been accepted.
- R2: A flit's kind sits in its top two bits: 01 head, 00 body, 10 tail. A head flit carries the destination X in bits [CW-1:0] and the destination Y in bits [2*CW-1:CW]. Ports are numbered 0 local, 1 east (+X), 2 west (-X), 3 north (+Y), 4 south (-Y). A head flit whose destination X is greater than the node X leaves on port 1, and one whose X is smaller leaves on port 2.
- R3: A head flit whose destination X equals the node X leaves on port 3 when its destination Y is greater than the node Y, and on port 4 when it is smaller.
- R4: A head flit whose destination X and Y both equal the node coordinates is ejected on port 0.
- R5: Once a head flit owns an output, only flits of that same packet appear on that output until its tail flit has passed. Competing packets wait in their FIFOs.
- R6: The flits of a packet leave on a single output, in the order they arrived, with their contents unchanged.
- R7: An output never has more than DEPTH flits outstanding that the downstream node has not yet credited. Each output's credit count starts at DEPTH.
- R8: An input returns exactly one credit pulse for each flit that leaves its FIFO. Over a run, the credits returned equal the flits accepted.
- R9: Head flits that compete for a free output are granted in round-robin order. The search starts at the port index after the last winner, and after reset it starts at port 1.
- R10: Request and reply planes are independent. Reply packets are delivered in full while every request output is starved of credits.
- R11: With no contention and credit available, a head flit appears at its output 2+LINK_DLY clock cycles after the cycle in which it is presented at an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_x | input | CW | X coordinate of this node |
| cur_y | input | CW | Y coordinate of this node |
| req_in_vld | input | 5 | Request plane: flit valid per input port |
| req_in_flit | input | 5*(DW+2) | Request plane: flit per input port, port p at bits [p*FW +: FW] |
| req_in_crd | output | 5 | Request plane: credit pulse back to each upstream sender |
| req_out_vld | output | 5 | Request plane: flit valid per output port |
| req_out_flit | output | 5*(DW+2) | Request plane: flit per output port |
| req_out_crd | input | 5 | Request plane: credit pulse from each downstream receiver |
| rsp_in_vld | input | 5 | Reply plane: flit valid per input port |
| rsp_in_flit | input | 5*(DW+2) | Reply plane: flit per input port |
| rsp_in_crd | output | 5 | Reply plane: credit pulse back to each upstream sender |
| rsp_out_vld | output | 5 | Reply plane: flit valid per output port |
| rsp_out_flit | output | 5*(DW+2) | Reply plane: flit per output port |
| rsp_out_crd | input | 5 | Reply plane: credit pulse from each downstream receiver |

## Verification
The checker relies on a few properties of the neighbours. Upstream senders drive a flit only while they hold a credit. Every packet is a head, zero or more body flits and a tail, with at least two flits. Downstream receivers return a credit only for a flit they have already received. The node coordinates stay fixed while traffic is in flight. The bench meets these rules by modelling each neighbour: it keeps a credit counter per upstream sender, issues credits downstream only from a count of flits it has received, and builds every packet from a helper that always adds a head and a tail. It withholds credits deliberately only on the downstream side, so that stalls are exercised without breaking the assumptions.

// File: rtl/mr_pkg.sv
package mr_pkg;

    localparam int NPORT = 5;
    localparam int PIDX_W = 3;
    localparam int NPLANE = 2;

    typedef enum logic [PIDX_W-1:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        K_BODY = 2'b00,
        K_HEAD = 2'b01,
        K_TAIL = 2'b10
    } kind_e;

endpackage

// File: rtl/mr_fifo.sv
module mr_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CNTW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != CNTW'(DEPTH)) || do_pop);
        if (do_push) begin
            s_d.mem[s_q.wr] = din;
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNTW'(do_push) - CNTW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.mem[s_q.rd];
    assign empty = (s_q.cnt == '0);

endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] gidx,
    output logic          any
);
    always_comb begin
        gidx = '0;
        any  = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int j;
            j = (int'(last) + off) % N;
            if (!any && req[j]) begin
                any  = 1'b1;
                gidx = IW'(j);
            end
        end
    end

endmodule

// File: rtl/mr_link.sv
module mr_link #(
    parameter int W   = 18,
    parameter int DLY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_f,
    output logic         out_v,
    output logic [W-1:0] out_f
);
    typedef struct packed {
        logic [DLY-1:0]        v;
        logic [DLY-1:0][W-1:0] f;
    } link_st_t;

    link_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.v[0] = in_v;
        s_d.f[0] = in_f;
        for (int k = 1; k < DLY; k++) begin
            s_d.v[k] = s_q.v[k-1];
            s_d.f[k] = s_q.f[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_v = s_q.v[DLY-1];
    assign out_f = s_q.f[DLY-1];

endmodule

// File: rtl/mr_plane.sv
module mr_plane
    import mr_pkg::*;
#(
    parameter int CW    = 3,
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int DLY   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           cur_x,
    input  logic [CW-1:0]           cur_y,
    input  logic [NPORT-1:0]        in_vld,
    input  logic [NPORT*(DW+2)-1:0] in_flit,
    output logic [NPORT-1:0]        in_crd,
    output logic [NPORT-1:0]        out_vld,
    output logic [NPORT*(DW+2)-1:0] out_flit,
    input  logic [NPORT-1:0]        out_crd
);
    localparam int FW  = DW + 2;
    localparam int NP  = NPORT;
    localparam int IW  = PIDX_W;
    localparam int CRW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NP-1:0]          bound;
        logic [NP-1:0][IW-1:0]  bsel;
        logic [NP-1:0]          busy;
        logic [NP-1:0][IW-1:0]  rrp;
        logic [NP-1:0][CRW-1:0] crd;
        logic [NP-1:0]          ret;
    } pl_st_t;

    pl_st_t s_d, s_q;

    logic [NP-1:0][FW-1:0] q_head;
    logic [NP-1:0]         q_empty;
    logic [NP-1:0]         pop;
    logic [NP-1:0][IW-1:0] route;
    logic [NP-1:0][NP-1:0] reqm;
    logic [NP-1:0][IW-1:0] gidx;
    logic [NP-1:0]         gany;
    logic [NP-1:0]         snd;
    logic [NP-1:0][FW-1:0] sflit;

    function automatic logic [IW-1:0] route_of(input logic [FW-1:0] f,
                                               input logic [CW-1:0] cx,
                                               input logic [CW-1:0] cy);
        logic [CW-1:0] dx, dy;
        dx = f[CW-1:0];
        dy = f[2*CW-1:CW];
        if (dx > cx)      return IW'(P_EAST);
        else if (dx < cx) return IW'(P_WEST);
        else if (dy > cy) return IW'(P_NORTH);
        else if (dy < cy) return IW'(P_SOUTH);
        else              return IW'(P_LOCAL);
    endfunction

    function automatic pl_st_t st_reset();
        pl_st_t r;
        r = '0;
        for (int o = 0; o < NP; o++) r.crd[o] = CRW'(DEPTH);
        return r;
    endfunction

    for (genvar i = 0; i < NP; i++) begin : g_in
        mr_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_vld[i]),
            .din   (in_flit[i*FW +: FW]),
            .pop   (pop[i]),
            .dout  (q_head[i]),
            .empty (q_empty[i])
        );
        assign route[i] = route_of(q_head[i], cur_x, cur_y);
    end

    always_comb begin
        reqm = '0;
        for (int i = 0; i < NP; i++) begin
            if (!q_empty[i] && !s_q.bound[i] && (q_head[i][FW-1 -: 2] == K_HEAD))
                reqm[route[i]][i] = 1'b1;
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        mr_rr_arb #(.N(NP), .IW(IW)) u_arb (
            .req  (reqm[o]),
            .last (s_q.rrp[o]),
            .gidx (gidx[o]),
            .any  (gany[o])
        );
        mr_link #(.W(FW), .DLY(DLY)) u_link (
            .clk   (clk),
            .rst_n (rst_n),
            .in_v  (snd[o]),
            .in_f  (sflit[o]),
            .out_v (out_vld[o]),
            .out_f (out_flit[o*FW +: FW])
        );
    end

    always_comb begin
        s_d   = s_q;
        pop   = '0;
        snd   = '0;
        sflit = '0;
        // allocation of idle outputs to waiting head flits
        for (int o = 0; o < NP; o++) begin
            if (!s_q.busy[o] && gany[o]) begin
                s_d.busy[o]        = 1'b1;
                s_d.bound[gidx[o]] = 1'b1;
                s_d.bsel[gidx[o]]  = IW'(o);
                s_d.rrp[o]         = gidx[o];
            end
        end
        // transfer along reserved paths when a credit is held
        for (int i = 0; i < NP; i++) begin
            if (s_q.bound[i] && !q_empty[i] && (s_q.crd[s_q.bsel[i]] != '0)) begin
                pop[i]               = 1'b1;
                snd[s_q.bsel[i]]     = 1'b1;
                sflit[s_q.bsel[i]]   = q_head[i];
                if (q_head[i][FW-1 -: 2] == K_TAIL) begin
                    s_d.bound[i]          = 1'b0;
                    s_d.busy[s_q.bsel[i]] = 1'b0;
                end
            end
        end
        for (int o = 0; o < NP; o++) begin
            s_d.crd[o] = s_q.crd[o] - CRW'(snd[o]) + CRW'(out_crd[o]);
        end
        s_d.ret = pop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= st_reset();
        else        s_q <= s_d;
    end

    assign in_crd = s_q.ret;

endmodule

// File: rtl/mesh_router_dual.sv
module mesh_router_dual
    import mr_pkg::*;
#(
    parameter int CW       = 3,
    parameter int DW       = 16,
    parameter int DEPTH    = 4,
    parameter int LINK_DLY = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           cur_x,
    input  logic [CW-1:0]           cur_y,
    input  logic [4:0]              req_in_vld,
    input  logic [5*(DW+2)-1:0]     req_in_flit,
    output logic [4:0]              req_in_crd,
    output logic [4:0]              req_out_vld,
    output logic [5*(DW+2)-1:0]     req_out_flit,
    input  logic [4:0]              req_out_crd,
    input  logic [4:0]              rsp_in_vld,
    input  logic [5*(DW+2)-1:0]     rsp_in_flit,
    output logic [4:0]              rsp_in_crd,
    output logic [4:0]              rsp_out_vld,
    output logic [5*(DW+2)-1:0]     rsp_out_flit,
    input  logic [4:0]              rsp_out_crd
);
    localparam int FW = DW + 2;
    localparam int BW = NPORT * FW;

    logic [NPLANE-1:0][NPORT-1:0] a_in_vld, a_in_crd, a_out_vld, a_out_crd;
    logic [NPLANE-1:0][BW-1:0]    a_in_flit, a_out_flit;

    assign a_in_vld[0]  = req_in_vld;
    assign a_in_vld[1]  = rsp_in_vld;
    assign a_in_flit[0] = req_in_flit;
    assign a_in_flit[1] = rsp_in_flit;
    assign a_out_crd[0] = req_out_crd;
    assign a_out_crd[1] = rsp_out_crd;

    for (genvar c = 0; c < NPLANE; c++) begin : g_plane
        mr_plane #(.CW(CW), .DW(DW), .DEPTH(DEPTH), .DLY(LINK_DLY)) u_plane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_x    (cur_x),
            .cur_y    (cur_y),
            .in_vld   (a_in_vld[c]),
            .in_flit  (a_in_flit[c]),
            .in_crd   (a_in_crd[c]),
            .out_vld  (a_out_vld[c]),
            .out_flit (a_out_flit[c]),
            .out_crd  (a_out_crd[c])
        );
    end

    assign req_in_crd   = a_in_crd[0];
    assign rsp_in_crd   = a_in_crd[1];
    assign req_out_vld  = a_out_vld[0];
    assign rsp_out_vld  = a_out_vld[1];
    assign req_out_flit = a_out_flit[0];
    assign rsp_out_flit = a_out_flit[1];

endmodule

// File: rtl/mr_chk.sv
module mr_chk #(
    parameter int CW    = 3,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CW-1:0]       cur_x,
    input logic [CW-1:0]       cur_y,
    input logic [4:0]          req_in_vld,
    input logic [5*(DW+2)-1:0] req_in_flit,
    input logic [4:0]          req_in_crd,
    input logic [4:0]          req_out_vld,
    input logic [5*(DW+2)-1:0] req_out_flit,
    input logic [4:0]          req_out_crd,
    input logic [4:0]          rsp_in_vld,
    input logic [5*(DW+2)-1:0] rsp_in_flit,
    input logic [4:0]          rsp_in_crd,
    input logic [4:0]          rsp_out_vld,
    input logic [5*(DW+2)-1:0] rsp_out_flit,
    input logic [4:0]          rsp_out_crd
);
    localparam int FW = DW + 2;

    logic [1:0][4:0]        iv, ic, ov, oc;
    logic [1:0][5*FW-1:0]   of;
    logic                   unused_bits;

    assign iv = {rsp_in_vld, req_in_vld};
    assign ic = {rsp_in_crd, req_in_crd};
    assign ov = {rsp_out_vld, req_out_vld};
    assign oc = {rsp_out_crd, req_out_crd};
    assign of = {rsp_out_flit, req_out_flit};
    assign unused_bits = ^{req_in_flit, rsp_in_flit, of};

    for (genvar c = 0; c < 2; c++) begin : g_c
        for (genvar p = 0; p < 5; p++) begin : g_p
            int            occ;
            int            infl;
            logic          open;
            logic [FW-1:0] f;
            logic          hd, tl;
            logic [CW-1:0] fx, fy;

            assign f  = of[c][p*FW +: FW];
            assign hd = ov[c][p] && (f[FW-1 -: 2] == 2'b01);
            assign tl = ov[c][p] && (f[FW-1 -: 2] == 2'b10);
            assign fx = f[CW-1:0];
            assign fy = f[2*CW-1:CW];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    occ  <= 0;
                    infl <= 0;
                    open <= 1'b0;
                end else begin
                    occ  <= occ + (ov[c][p] ? 1 : 0) - (oc[c][p] ? 1 : 0);
                    infl <= infl + (iv[c][p] ? 1 : 0) - (ic[c][p] ? 1 : 0);
                    if (hd)      open <= 1'b1;
                    else if (tl) open <= 1'b0;
                end
            end

            AST_ROUTE_X: assert property (@(posedge clk) disable iff (!rst_n)
                (hd && (p == 1 || p == 2)) |-> ((p == 1) ? (fx > cur_x) : (fx < cur_x))); // R2
            AST_ROUTE_Y: assert property (@(posedge clk) disable iff (!rst_n)
                (hd && (p == 3 || p == 4)) |-> (fx == cur_x && ((p == 3) ? (fy > cur_y) : (fy < cur_y)))); // R3
            AST_EJECT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
                (hd && p == 0) |-> (fx == cur_x && fy == cur_y)); // R4
            AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
                (ov[c][p] && open) |-> !hd); // R5
            AST_BODY_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
                (ov[c][p] && !open) |-> hd); // R5
            AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                occ <= DEPTH); // R7
            AST_CRD_AFTER_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
                ic[c][p] |-> (infl > 0)); // R8
        end
    end

endmodule

bind mesh_router_dual mr_chk #(.CW(CW), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/mesh_router_dual_tb.sv
`timescale 1ns/1ps
module mesh_router_dual_tb;
    localparam int CW = 3, DW = 16, DEPTH = 4, LINK_DLY = 2;
    localparam int FW = DW + 2, NQ = 10, MAXP = 1024;
    localparam int CX = 3, CY = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [CW-1:0] cur_x = CW'(CX), cur_y = CW'(CY);
    logic [4:0] req_in_vld, req_in_crd, req_out_vld, req_out_crd;
    logic [4:0] rsp_in_vld, rsp_in_crd, rsp_out_vld, rsp_out_crd;
    logic [5*FW-1:0] req_in_flit, req_out_flit, rsp_in_flit, rsp_out_flit;

    always #4 clk = ~clk;

    mesh_router_dual #(.CW(CW), .DW(DW), .DEPTH(DEPTH), .LINK_DLY(LINK_DLY)) u_dut (.*);

    logic [FW-1:0] txq [NQ][$];
    int up_crd[NQ], dn_pend[NQ], dn_occ[NQ], open_pid[NQ], flits_tx[NQ], crd_rx[NQ];
    bit hold[NQ];
    int pk_len[MAXP], pk_rx[MAXP], pk_port[MAXP], pk_plane[MAXP], pk_tx[MAXP], pk_rxt[MAXP];
    int npk = 0, rate = 100, tick_n = 0, nvec = 0, nfail = 0;
    int outlog[$];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_port(input int dx, input int dy);
        if (dx > CX) return 1;
        if (dx < CX) return 2;
        if (dy > CY) return 3;
        if (dy < CY) return 4;
        return 0;
    endfunction

    task automatic add_pkt(input int c, input int p, input int dx, input int dy, input int len, output int pid);
        pid = npk++;
        pk_len[pid] = len; pk_rx[pid] = 0; pk_plane[pid] = c;
        pk_port[pid] = exp_port(dx, dy);
        for (int s = 0; s < len; s++) begin
            logic [1:0] k;
            logic [5:0] lo;
            k  = (s == 0) ? 2'b01 : ((s == len - 1) ? 2'b10 : 2'b00);
            lo = (s == 0) ? {3'(dy), 3'(dx)} : 6'(s);
            txq[c*5+p].push_back({k, 10'(pid), lo});
        end
    endtask

    task automatic take(input int k, input logic [FW-1:0] f);
        int pid, c, p, rx;
        string rq;
        c = k / 5; p = k % 5;
        pid = int'(f[15:6]);
        if (pid >= npk) begin chk(0, "R6", "unknown packet id", pid, npk); return; end
        rx = pk_rx[pid];
        chk(pk_plane[pid] == c, "R10", "plane of packet", c, pk_plane[pid]);
        rq = (pk_port[pid] == 0) ? "R4" : ((pk_port[pid] <= 2) ? "R2" : "R3");
        chk(p == pk_port[pid], rq, "output port", p, pk_port[pid]);
        if (open_pid[k] >= 0) chk(pid == open_pid[k], "R5", "interleaved packet", pid, open_pid[k]);
        chk(int'(f[17:16]) == ((rx == 0) ? 1 : ((rx == pk_len[pid] - 1) ? 2 : 0)), "R6", "flit kind",
            int'(f[17:16]), (rx == 0) ? 1 : ((rx == pk_len[pid] - 1) ? 2 : 0));
        if (rx != 0) chk(int'(f[5:0]) == rx, "R6", "flit sequence", int'(f[5:0]), rx);
        if (f[17:16] == 2'b01) open_pid[k] = pid;
        if (f[17:16] == 2'b10) open_pid[k] = -1;
        if (rx == 0) pk_rxt[pid] = tick_n;
        if (c == 0 && p == 0 && f[17:16] == 2'b01) outlog.push_back(pid);
        pk_rx[pid] = rx + 1;
        dn_pend[k]++; dn_occ[k]++;
        chk(dn_occ[k] <= DEPTH, "R7", "uncredited flits at output", dn_occ[k], DEPTH);
    endtask

    task automatic tick();
        logic [4:0] nv[2], nc[2];
        logic [5*FW-1:0] nf[2];
        @(negedge clk);
        tick_n++;
        for (int k = 0; k < NQ; k++) begin
            int c, p;
            c = k / 5; p = k % 5;
            if ((c == 0) ? req_in_crd[p] : rsp_in_crd[p]) begin up_crd[k]++; crd_rx[k]++; end
            if ((c == 0) ? req_out_vld[p] : rsp_out_vld[p])
                take(k, (c == 0) ? req_out_flit[p*FW +: FW] : rsp_out_flit[p*FW +: FW]);
        end
        for (int c = 0; c < 2; c++) begin nv[c] = '0; nc[c] = '0; nf[c] = '0; end
        for (int k = 0; k < NQ; k++) begin
            int c, p;
            c = k / 5; p = k % 5;
            if (!hold[k] && dn_pend[k] > 0 && $urandom_range(99) < 70) begin
                nc[c][p] = 1'b1; dn_pend[k]--; dn_occ[k]--;
            end
            if (txq[k].size() > 0 && up_crd[k] > 0 && $urandom_range(99) < rate) begin
                logic [FW-1:0] f;
                f = txq[k].pop_front();
                nv[c][p] = 1'b1; nf[c][p*FW +: FW] = f;
                up_crd[k]--; flits_tx[k]++;
                if (f[17:16] == 2'b01) pk_tx[int'(f[15:6])] = tick_n;
            end
        end
        req_in_vld = nv[0]; req_in_flit = nf[0]; req_out_crd = nc[0];
        rsp_in_vld = nv[1]; rsp_in_flit = nf[1]; rsp_out_crd = nc[1];
    endtask

    function automatic bit plane_done(input int c);
        for (int p = 0; p < 5; p++) if (txq[c*5+p].size() != 0) return 0;
        for (int i = 0; i < npk; i++) if (pk_plane[i] == c && pk_rx[i] != pk_len[i]) return 0;
        return 1;
    endfunction

    task automatic drain(input int c0, input int c1, input int limit, output bit ok);
        ok = 0;
        for (int n = 0; n < limit; n++) begin
            if (plane_done(c0) && plane_done(c1)) begin ok = 1; break; end
            tick();
        end
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired (all requirements): actual %0d expected %0d", tick_n, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int pid, a[6];
        bit ok;
        void'($urandom(32'd1234));
        for (int k = 0; k < NQ; k++) begin
            up_crd[k] = DEPTH; dn_pend[k] = 0; dn_occ[k] = 0; open_pid[k] = -1;
            flits_tx[k] = 0; crd_rx[k] = 0; hold[k] = 0;
        end
        rst_n = 1'b0;
        req_in_vld = '0; req_in_flit = '0; req_out_crd = '0;
        rsp_in_vld = '0; rsp_in_flit = '0; rsp_out_crd = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int n = 0; n < 5; n++) begin
            tick();
            chk(req_out_vld == 0 && rsp_out_vld == 0, "R1", "output valid after reset",
                int'({req_out_vld, rsp_out_vld}), 0);
            chk(req_in_crd == 0 && rsp_in_crd == 0, "R1", "credit pulse after reset",
                int'({req_in_crd, rsp_in_crd}), 0);
        end
        // R11: uncontended latency, reply plane, local in -> east out
        rate = 100;
        add_pkt(1, 0, CX + 1, CY, 2, pid);
        drain(1, 1, 200, ok);
        chk(ok, "R11", "latency packet drained", int'(ok), 1);
        chk(pk_rxt[pid] - pk_tx[pid] == 2 + LINK_DLY, "R11", "head latency in cycles",
            pk_rxt[pid] - pk_tx[pid], 2 + LINK_DLY);
        // R9: three inputs contend for the local output of the request plane
        outlog.delete();
        for (int r = 0; r < 2; r++)
            for (int p = 1; p <= 3; p++) add_pkt(0, p, CX, CY, 2, a[r*3+p-1]);
        drain(0, 0, 2000, ok);
        chk(ok, "R9", "contending packets drained", int'(ok), 1);
        chk(outlog.size() == 6, "R9", "packets ejected", outlog.size(), 6);
        for (int n = 0; n < 6 && n < outlog.size(); n++)
            chk(outlog[n] == a[n], "R9", "round-robin grant order", outlog[n], a[n]);
        // R10: request plane starved, reply plane must still deliver
        for (int k = 0; k < 5; k++) hold[k] = 1;
        for (int p = 0; p < 5; p++)
            for (int r = 0; r < 2; r++)
                add_pkt(0, p, $urandom_range(7), $urandom_range(7), 4, pid);
        repeat (40) tick();
        for (int r = 0; r < 8; r++)
            add_pkt(1, $urandom_range(4), $urandom_range(7), $urandom_range(7), 2 + $urandom_range(3), pid);
        drain(1, 1, 3000, ok);
        chk(ok, "R10", "reply traffic delivered while requests stalled", int'(ok), 1);
        chk(!plane_done(0), "R10", "request plane held by credits", int'(plane_done(0)), 0);
        for (int k = 0; k < 5; k++) hold[k] = 0;
        drain(0, 1, 5000, ok);
        chk(ok, "R7", "request traffic drains after credits resume", int'(ok), 1);
        // R2..R6: random mixed traffic over both planes
        rate = 60;
        for (int r = 0; r < 150; r++)
            add_pkt($urandom_range(1), $urandom_range(4), $urandom_range(7), $urandom_range(7),
                    2 + $urandom_range(4), pid);
        drain(0, 1, 60000, ok);
        chk(ok, "R6", "all random packets complete", int'(ok), 1);
        repeat (10) tick();
        for (int k = 0; k < NQ; k++)
            chk(crd_rx[k] == flits_tx[k], "R8", "credits returned versus flits accepted",
                crd_rx[k], flits_tx[k]);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule